// File: doc/BRIEF.md
# Floating-Point Sticky Status Flags

This block keeps the exception status of a single-precision floating-point datapath. The arithmetic unit signals the end of each operation with a one-cycle valid pulse and a six-bit vector of raw exceptions. The block folds that vector onto five accumulating status bits and one summary bit.

The five accumulating bits are invalid, overflow, divide-by-zero, underflow and inexact. The summary bit reflects only the most recent operation. Several raw causes can feed one status bit, and the output-denormal cause feeds both underflow and inexact.

Software reloads the status through a masked-write command that carries a 16-bit operand: eight value bits and eight mask bits. The same command sets a two-bit rounding mode. A combinational read-back word returns the whole state in the same layout the write operand uses.

Top module: `fp_status_flags`

## Requirements
- R1: A synchronous active-high reset clears all six flag outputs and sets the rounding mode to 00. It does so even when it arrives while the flags are set.
- R2: An operation pulse whose raw vector has bit 0 (invalid) set sets the invalid flag. Bit 1 (overflow) sets the overflow flag, and bit 4 (divide-by-zero) sets the divide-by-zero flag. Each of these flags stays set until a masked write or a reset changes it.
- R3: Raw bit 2 (underflow) or raw bit 3 (output-denormal) sets the underflow flag, and the flag stays set.
- R4: Raw bit 5 (inexact) or raw bit 3 (output-denormal) sets the inexact flag, and the flag stays set.
- R5: After an operation pulse, the summary flag is 1 if the raw vector had any bit set and 0 otherwise. A clean operation changes none of the five accumulating flags.
- R6: While neither an operation pulse nor a masked write is present, the raw vector is ignored and every output keeps its value.
- R7: The masked write takes value bits [7:2] and mask bits [15:10]. They map to summary (7/15), invalid (6/14), overflow (5/13), divide-by-zero (4/12), underflow (3/11) and inexact (2/10). Summary, invalid, overflow, divide-by-zero and underflow each become value AND mask, so a flag with a clear mask bit is cleared.
- R8: On a masked write, the inexact flag keeps its old value when mask bit 10 is 0. When mask bit 10 is 1, the inexact flag takes value bit 2.
- R9: On a masked write, each rounding-mode bit i takes value bit i when mask bit 8+i is set, and keeps its old value otherwise.
- R10: When a masked write and an operation pulse arrive in the same cycle, only the masked write takes effect.
- R11: The read-back word has bit 7 summary, bit 6 invalid, bit 5 overflow, bit 4 divide-by-zero, bit 3 underflow, bit 2 inexact, bits 1:0 rounding mode, and bits 15:8 zero. It reflects the state after the last clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle pulse marking a finished operation |
| op_exc | input | 6 | Raw exceptions: 0 invalid, 1 overflow, 2 underflow, 3 output-denormal, 4 divide-by-zero, 5 inexact |
| wr_en | input | 1 | Masked-write command strobe |
| wr_data | input | 16 | Masked-write operand: mask in [15:8], value in [7:0] |
| flag_summary | output | 1 | Last operation reported an exception |
| flag_invalid | output | 1 | Sticky invalid |
| flag_overflow | output | 1 | Sticky overflow |
| flag_divzero | output | 1 | Sticky divide-by-zero |
| flag_underflow | output | 1 | Sticky underflow |
| flag_inexact | output | 1 | Sticky inexact |
| round_mode | output | 2 | Rounding mode |
| rd_word | output | 16 | Read-back word |

## Verification
The bench builds the block with its default parameters: a two-bit rounding mode that resets to 00. With two rounding-mode bits, each of the mask bits 8 and 9 can be exercised on its own. That makes the per-bit retention of the rounding mode observable.

The stimulus covers every raw cause, alone and combined, with and without the valid pulse. It also issues masked writes with mixed masks, including writes that race an operation pulse. Each cycle's outputs are compared against a behavioural model.

// File: rtl/fpsf_pkg.sv
package fpsf_pkg;

   localparam int unsigned EXC_W   = 6;
   localparam int unsigned OPND_W  = 16;
   localparam int unsigned MASK_LO = 8;

   localparam int unsigned EXC_INVALID   = 0;
   localparam int unsigned EXC_OVERFLOW  = 1;
   localparam int unsigned EXC_UNDERFLOW = 2;
   localparam int unsigned EXC_DENORM    = 3;
   localparam int unsigned EXC_DIVZERO   = 4;
   localparam int unsigned EXC_INEXACT   = 5;

   // field order matches operand bits [7:2] (MSB first)
   typedef struct packed {
      logic any;
      logic inv;
      logic ovf;
      logic dbz;
      logic unf;
      logic inx;
   } fpsf_flags_t;

   localparam int unsigned FLAG_W  = $bits(fpsf_flags_t);
   localparam int unsigned FLAG_LO = 2;

endpackage

// File: rtl/fpsf_event_map.sv
module fpsf_event_map
   import fpsf_pkg::*;
(
   input  logic [EXC_W-1:0] exc,
   output fpsf_flags_t      set_bits
);

   always_comb begin
      set_bits.any = |exc;
      set_bits.inv = exc[EXC_INVALID];
      set_bits.ovf = exc[EXC_OVERFLOW];
      set_bits.dbz = exc[EXC_DIVZERO];
      set_bits.unf = exc[EXC_UNDERFLOW] | exc[EXC_DENORM];
      set_bits.inx = exc[EXC_INEXACT]   | exc[EXC_DENORM];
   end

endmodule

// File: rtl/fpsf_wr_decode.sv
module fpsf_wr_decode
   import fpsf_pkg::*;
#(
   parameter int unsigned RM_W = 2
)(
   input  logic [OPND_W-1:0] opnd,
   output fpsf_flags_t       flg_val,
   output fpsf_flags_t       flg_msk,
   output logic [RM_W-1:0]   rm_val,
   output logic [RM_W-1:0]   rm_msk
);

   logic [FLAG_W-1:0] val_vec;
   logic [FLAG_W-1:0] msk_vec;

   for (genvar gi = 0; gi < FLAG_W; gi++) begin : g_flag
      assign msk_vec[gi] = opnd[MASK_LO + FLAG_LO + gi];
      assign val_vec[gi] = opnd[FLAG_LO + gi] & msk_vec[gi];
   end

   assign flg_val = fpsf_flags_t'(val_vec);
   assign flg_msk = fpsf_flags_t'(msk_vec);

   for (genvar gr = 0; gr < RM_W; gr++) begin : g_rm
      assign rm_msk[gr] = opnd[MASK_LO + gr];
      assign rm_val[gr] = opnd[gr];
   end

endmodule

// File: rtl/fp_status_flags.sv
module fp_status_flags
   import fpsf_pkg::*;
#(
   parameter int unsigned RM_W   = 2,
   parameter int unsigned RM_RST = 0
)(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 op_valid,
   input  logic [EXC_W-1:0]     op_exc,
   input  logic                 wr_en,
   input  logic [OPND_W-1:0]    wr_data,
   output logic                 flag_summary,
   output logic                 flag_invalid,
   output logic                 flag_overflow,
   output logic                 flag_divzero,
   output logic                 flag_underflow,
   output logic                 flag_inexact,
   output logic [RM_W-1:0]      round_mode,
   output logic [OPND_W-1:0]    rd_word
);

   localparam int unsigned RD_PAD = OPND_W - FLAG_W - FLAG_LO;
   localparam int unsigned RM_PAD = FLAG_LO - RM_W;

   if (RM_W < 1 || RM_W > FLAG_LO) begin : g_bad_rm_w
      $error("fp_status_flags: RM_W must be 1..%0d", FLAG_LO);
   end
   if (RM_RST >= (1 << RM_W)) begin : g_bad_rm_rst
      $error("fp_status_flags: RM_RST does not fit in RM_W bits");
   end

   fpsf_flags_t       set_bits;
   fpsf_flags_t       wr_val;
   fpsf_flags_t       wr_msk;
   logic [RM_W-1:0]   wr_rm_val;
   logic [RM_W-1:0]   wr_rm_msk;

   fpsf_flags_t       flg_q, flg_d;
   logic [RM_W-1:0]   rm_q, rm_d;

   fpsf_event_map u_map (
      .exc      (op_exc),
      .set_bits (set_bits)
   );

   fpsf_wr_decode #(.RM_W(RM_W)) u_dec (
      .opnd    (wr_data),
      .flg_val (wr_val),
      .flg_msk (wr_msk),
      .rm_val  (wr_rm_val),
      .rm_msk  (wr_rm_msk)
   );

   always_comb begin
      flg_d = flg_q;
      rm_d  = rm_q;
      if (wr_en) begin
         flg_d     = wr_val;
         flg_d.inx = (flg_q.inx & ~wr_msk.inx) | wr_val.inx;
         rm_d      = (rm_q & ~wr_rm_msk) | (wr_rm_val & wr_rm_msk);
      end else if (op_valid) begin
         flg_d.any = set_bits.any;
         flg_d.inv = flg_q.inv | set_bits.inv;
         flg_d.ovf = flg_q.ovf | set_bits.ovf;
         flg_d.dbz = flg_q.dbz | set_bits.dbz;
         flg_d.unf = flg_q.unf | set_bits.unf;
         flg_d.inx = flg_q.inx | set_bits.inx;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         flg_q <= '0;
         rm_q  <= RM_W'(RM_RST);
      end else begin
         flg_q <= flg_d;
         rm_q  <= rm_d;
      end
   end

   assign flag_summary   = flg_q.any;
   assign flag_invalid   = flg_q.inv;
   assign flag_overflow  = flg_q.ovf;
   assign flag_divzero   = flg_q.dbz;
   assign flag_underflow = flg_q.unf;
   assign flag_inexact   = flg_q.inx;
   assign round_mode     = rm_q;

   if (RM_PAD == 0) begin : g_rd_full
      assign rd_word = {{RD_PAD{1'b0}}, flg_q, rm_q};
   end else begin : g_rd_pad
      assign rd_word = {{RD_PAD{1'b0}}, flg_q, {RM_PAD{1'b0}}, rm_q};
   end

   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> (flg_q == '0 && rm_q == RM_W'(RM_RST)));

   assert_invalid_sets_R2: assert property (@(posedge clk) disable iff (rst)
      (op_valid && !wr_en && op_exc[EXC_INVALID]) |=> flag_invalid);

   assert_denorm_both_R3: assert property (@(posedge clk) disable iff (rst)
      (op_valid && !wr_en && op_exc[EXC_DENORM]) |=> (flag_underflow && flag_inexact));

   assert_clean_op_R5: assert property (@(posedge clk) disable iff (rst)
      (op_valid && !wr_en && op_exc == '0) |=> (!flag_summary && $stable(rd_word[6:2])));

   assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (!op_valid && !wr_en) |=> $stable(rd_word));

   assert_write_clears_R7: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_data[15:11] == '0) |=> (rd_word[7:3] == '0));

   assert_inexact_keep_R8: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_data[10]) |=> $stable(flag_inexact));

   assert_rm_keep_R9: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_data[MASK_LO +: RM_W] == '0) |=> $stable(round_mode));

   assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
      (wr_en && op_valid) |=> (flag_summary == $past(wr_data[7] & wr_data[15])));

endmodule

// File: tb/fp_status_flags_bench.sv
module fp_status_flags_bench;

   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst;
   logic        op_valid;
   logic [5:0]  op_exc;
   logic        wr_en;
   logic [15:0] wr_data;
   logic        flag_summary, flag_invalid, flag_overflow;
   logic        flag_divzero, flag_underflow, flag_inexact;
   logic [1:0]  round_mode;
   logic [15:0] rd_word;

   int compared   = 0;
   int mismatched = 0;
   bit done       = 1'b0;

   // behavioural reference state
   bit m_any, m_inv, m_ovf, m_dbz, m_unf, m_inx;
   bit [1:0] m_rm;

   always #(CLK_PERIOD/2) clk = ~clk;

   fp_status_flags u_fp_status_flags (
      .clk            (clk),
      .rst            (rst),
      .op_valid       (op_valid),
      .op_exc         (op_exc),
      .wr_en          (wr_en),
      .wr_data        (wr_data),
      .flag_summary   (flag_summary),
      .flag_invalid   (flag_invalid),
      .flag_overflow  (flag_overflow),
      .flag_divzero   (flag_divzero),
      .flag_underflow (flag_underflow),
      .flag_inexact   (flag_inexact),
      .round_mode     (round_mode),
      .rd_word        (rd_word)
   );

   function automatic bit [15:0] model_word();
      return {8'h00, m_any, m_inv, m_ovf, m_dbz, m_unf, m_inx, m_rm};
   endfunction

   task automatic compare(input string tag);
      bit [15:0] exp_w = model_word();
      bit [15:0] act_w = {8'h00, flag_summary, flag_invalid, flag_overflow,
                          flag_divzero, flag_underflow, flag_inexact, round_mode};
      compared++;
      if (act_w !== exp_w || rd_word !== exp_w) begin
         mismatched++;
         $display("FAIL %s: outputs=%h rd_word=%h expected=%h at %0t",
                  tag, act_w, rd_word, exp_w, $time);
      end
   endtask

   // called at a falling edge; drives, clocks, updates model, compares
   task automatic step(input bit v, input bit [5:0] e, input bit w,
                       input bit [15:0] d, input string tag);
      op_valid = v; op_exc = e; wr_en = w; wr_data = d; rst = 1'b0;
      @(posedge clk);
      if (w) begin
         m_any = d[7] & d[15];
         m_inv = d[6] & d[14];
         m_ovf = d[5] & d[13];
         m_dbz = d[4] & d[12];
         m_unf = d[3] & d[11];
         if (d[10]) m_inx = d[2];
         if (d[8])  m_rm[0] = d[0];
         if (d[9])  m_rm[1] = d[1];
      end else if (v) begin
         m_any = (e != 0);
         if (e[0]) m_inv = 1;
         if (e[1]) m_ovf = 1;
         if (e[4]) m_dbz = 1;
         if (e[2] || e[3]) m_unf = 1;
         if (e[5] || e[3]) m_inx = 1;
      end
      @(negedge clk);
      compare(tag);
   endtask

   task automatic do_reset(input string tag);
      rst = 1'b1; op_valid = 0; op_exc = '0; wr_en = 0; wr_data = '0;
      @(posedge clk);
      {m_any, m_inv, m_ovf, m_dbz, m_unf, m_inx} = '0;
      m_rm = 2'b00;
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; op_valid = 0; op_exc = '0; wr_en = 0; wr_data = '0;
      @(negedge clk);
      do_reset("R1 reset state");

      step(1, 6'b000001, 0, 16'h0, "R2 invalid");
      step(1, 6'b000000, 0, 16'h0, "R5 clean op clears summary");
      step(1, 6'b000010, 0, 16'h0, "R2 overflow");
      step(1, 6'b010000, 0, 16'h0, "R2 divzero");
      step(0, 6'b111111, 0, 16'h0, "R6 vector ignored without pulse");
      step(0, 6'b000000, 0, 16'h0, "R6 idle hold");
      step(1, 6'b000000, 0, 16'h0, "R5 sticky untouched");

      step(1, 6'b000000, 1, 16'h0000, "R7 mask zero clears");
      step(1, 6'b000100, 0, 16'h0, "R3 underflow");
      step(1, 6'b001000, 0, 16'hFFFF, "R3 denorm");
      step(1, 6'b001000, 0, 16'h0, "R4 denorm sets both");
      step(0, 6'b000000, 1, 16'h0400, "R8 clear inexact via mask");
      step(1, 6'b100000, 0, 16'h0, "R4 inexact");
      step(1, 6'b000000, 0, 16'h0, "R5 clean keeps inexact");

      step(0, 6'b000000, 1, 16'hFCFC, "R7 all flags set by write");
      step(0, 6'b000000, 1, 16'h0004, "R8 inexact kept, others cleared");
      step(0, 6'b000000, 1, 16'h5050, "R7 mixed masks");
      step(0, 6'b000000, 1, 16'hA0E0, "R7 value without mask");
      step(0, 6'b000000, 1, 16'h0400, "R8 mask set value zero");
      step(0, 6'b000000, 1, 16'h0404, "R8 mask set value one");
      step(0, 6'b000000, 1, 16'h0000, "R8 preserved");

      step(0, 6'b000000, 1, 16'h0303, "R9 both rm bits");
      step(0, 6'b000000, 1, 16'h0100, "R9 bit0 only");
      step(0, 6'b000000, 1, 16'h0202, "R9 bit1 only");
      step(0, 6'b000000, 1, 16'h0003, "R9 no mask keeps rm");
      step(1, 6'b111111, 0, 16'h0, "R11 readback all flags");

      step(1, 6'b111111, 1, 16'h0000, "R10 write wins over op");
      step(1, 6'b000000, 1, 16'h8080, "R10 write summary over clean op");
      step(1, 6'b000011, 0, 16'h0, "R5 summary after exceptions");

      step(0, 6'b000000, 1, 16'h0303, "R9 set rm before reset");
      do_reset("R1 reset while set");
      step(0, 6'b000000, 0, 16'h0, "R11 readback after reset");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule